// File: doc/BRIEF.md
# Nibble-Serial Quadlet Check-Value Engine

This block computes the 16-bit check value that guards configuration-ROM and map blocks on a serial-bus node. A one-cycle start pulse loads the number of quadlets to cover and clears the accumulator. The 32-bit quadlets then arrive over a valid/ready handshake. The block folds each quadlet into the accumulator four bits per clock, taking the top nibble first.

The first nibble is folded in during the clock that accepts the quadlet. The remaining seven nibbles take one clock each from a shift register, so a quadlet takes eight clocks. After the last nibble of the last quadlet the block raises a done flag. It then presents the check value and a header quadlet that packs the covered length together with the check value. Both stay put until the next start.

Top module: `cfgrom_crc_engine`

## Requirements
- R1: A start pulse with a non-zero length clears the check value to 0 and latches the length. In the next cycle done is low and in_ready is high.
- R2: A quadlet is taken only on a cycle with in_valid and in_ready both high. While the block waits and in_valid is low, the check value and in_ready do not change.
- R3: Each quadlet is folded in as eight nibbles, from bits 31:28 down to bits 3:0, and the value is kept to 16 bits.
- R4: For each nibble, s = (value[15:12] XOR nibble). The new value is (value << 4) XOR (s << 12) XOR (s << 5) XOR s, kept to 16 bits. From a zero value, the quadlet 0x0000000F gives 0xF1EF.
- R5: Each quadlet takes exactly eight clocks. in_ready stays low for the seven cycles after an acceptance. If quadlets remain, in_ready is high again in the eighth cycle.
- R6: A start with length 0 raises done in the next cycle, with check value 0 and header 0.
- R7: header holds the latched length, zero-extended to 16 bits, in bits 31:16 and the check value in bits 15:0.
- R8: Once done is high, it stays high with check value and header unchanged until the next start. in_valid has no effect in this state.
- R9: A start during a block abandons that block and begins a new one from a zero value.
- R10: done rises in the cycle after the last nibble is folded in. in_ready is never high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new block; takes priority over all else |
| len_quads | input | LEN_W | Number of quadlets to cover, sampled with start |
| in_valid | input | 1 | Quadlet on in_data is offered |
| in_data | input | 32 | Quadlet to fold in |
| in_ready | output | 1 | Block can take a quadlet this cycle |
| done | output | 1 | All quadlets of the block are folded in |
| crc | output | 16 | Running, then final, check value |
| header | output | 32 | {length, check value} |

## Verification
A wrong nibble order or a wrong feedback tap shows in the check value once the block completes. The first quadlet with a non-zero nibble in the affected position is enough to expose it. A miscount in the nibble counter moves the rise of in_ready or done away from the eighth cycle, and this is seen within the first quadlet. A fault in the quadlet counter shows as done arriving one quadlet early or late. The header check then also flags the length field. An acceptance without a handshake corrupts the final value of the block in which it occurs.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;
    localparam int CRC_W  = 16;
    localparam int QUAD_W = 32;
    localparam int NIB_W  = 4;
    localparam int NIBS   = QUAD_W / NIB_W;
    localparam int CNT_W  = $clog2(NIBS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TAKE,
        ST_SHIFT,
        ST_DONE
    } crc_state_e;
endpackage

// File: rtl/crc_nib_step.sv
module crc_nib_step
    import cfgcrc_pkg::*;
(
    input  logic [CRC_W-1:0] acc_in,
    input  logic [NIB_W-1:0] nib,
    output logic [CRC_W-1:0] acc_out
);
    logic [NIB_W-1:0] fb;

    always_comb begin
        fb      = acc_in[CRC_W-1 -: NIB_W] ^ nib;
        acc_out = (acc_in << NIB_W)
                ^ (CRC_W'(fb) << 12)
                ^ (CRC_W'(fb) << 5)
                ^ CRC_W'(fb);
    end
endmodule

// File: rtl/crc_hdr_pack.sv
module crc_hdr_pack
    import cfgcrc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [CRC_W-1:0]  crc,
    output logic [QUAD_W-1:0] hdr
);
    localparam int FLD_W = QUAD_W - CRC_W;

    generate
        if (LEN_W >= FLD_W) begin : g_trunc
            assign hdr = {len[FLD_W-1:0], crc};
        end else begin : g_ext
            assign hdr = {{(FLD_W-LEN_W){1'b0}}, len, crc};
        end
    endgenerate
endmodule

// File: rtl/cfgrom_crc_engine.sv
module cfgrom_crc_engine
    import cfgcrc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_quads,
    input  logic              in_valid,
    input  logic [QUAD_W-1:0] in_data,
    output logic              in_ready,
    output logic              done,
    output logic [CRC_W-1:0]  crc,
    output logic [QUAD_W-1:0] header
);
    typedef struct packed {
        crc_state_e        st;
        logic [CRC_W-1:0]  acc;
        logic [QUAD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [LEN_W-1:0]  remain;
        logic [LEN_W-1:0]  len;
    } regs_t;

    regs_t r_d, r_q;
    logic [NIB_W-1:0] nib_src;
    logic [CRC_W-1:0] acc_nx;

    crc_nib_step u_step (
        .acc_in  (r_q.acc),
        .nib     (nib_src),
        .acc_out (acc_nx)
    );

    crc_hdr_pack #(.LEN_W(LEN_W)) u_hdr (
        .len (r_q.len),
        .crc (r_q.acc),
        .hdr (header)
    );

    always_comb begin
        r_d     = r_q;
        nib_src = (r_q.st == ST_TAKE) ? in_data[QUAD_W-1 -: NIB_W]
                                      : r_q.sh[QUAD_W-1 -: NIB_W];
        if (start) begin
            r_d.acc    = '0;
            r_d.len    = len_quads;
            r_d.remain = len_quads;
            r_d.cnt    = '0;
            r_d.st     = (len_quads == '0) ? ST_DONE : ST_TAKE;
        end else begin
            case (r_q.st)
                ST_TAKE: begin
                    if (in_valid) begin
                        r_d.acc = acc_nx;
                        r_d.sh  = in_data << NIB_W;
                        r_d.cnt = CNT_W'(NIBS - 1);
                        r_d.st  = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    r_d.acc = acc_nx;
                    r_d.sh  = r_q.sh << NIB_W;
                    r_d.cnt = r_q.cnt - 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.remain = r_q.remain - 1'b1;
                        r_d.st     = (r_q.remain == LEN_W'(1)) ? ST_DONE : ST_TAKE;
                    end
                end
                default: r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, acc: '0, sh: '0, cnt: '0, remain: '0, len: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.st == ST_TAKE);
    assign done     = (r_q.st == ST_DONE);
    assign crc      = r_q.acc;
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
    import cfgcrc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  len_quads,
    input logic              in_valid,
    input logic              in_ready,
    input logic              done,
    input logic [CRC_W-1:0]  crc,
    input logic [QUAD_W-1:0] header
);
    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    busy_cnt <= '0;
        else if (start)                busy_cnt <= '0;
        else if (in_valid && in_ready) busy_cnt <= CNT_W'(NIBS - 1);
        else if (busy_cnt != '0)       busy_cnt <= busy_cnt - 1'b1;
    end

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len_quads != '0) |=> (!done && crc == '0 && in_ready)); // R1
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid && !start) |=> ($stable(crc) && in_ready)); // R2
    AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |-> !in_ready); // R5
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len_quads == '0) |=> (done && crc == '0 && header == '0)); // R6
    AST_HDR_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (header[CRC_W-1:0] == crc)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(crc) && $stable(header))); // R8
    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && in_ready)); // R10
endmodule

bind cfgrom_crc_engine crc_engine_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len_quads (len_quads),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .done      (done),
    .crc       (crc),
    .header    (header)
);

// File: tb/sim_cfgrom_crc_engine.sv
module sim_cfgrom_crc_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] len_quads = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, done;
    logic [15:0] crc;
    logic [31:0] header;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    cfgrom_crc_engine #(.LEN_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .len_quads(len_quads),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .done(done), .crc(crc), .header(header)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, WDOG);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    function automatic logic [15:0] model_quad(input logic [15:0] acc, input logic [31:0] q);
        int v = int'(acc);
        for (int k = 28; k >= 0; k -= 4) begin
            int s = ((v >> 12) ^ int'(q >> k)) & 15;
            v = (v << 4) ^ (s << 12) ^ (s << 5) ^ s;
        end
        return 16'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input int n);
        start = 1'b1;
        len_quads = 16'(n);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed_block(input int n, input int gap_max);
        logic [15:0] m = '0;
        do_start(n);
        if (n == 0) begin
            chk(done == 1'b1, "R6 done", 32'(done), 32'd1);
            chk(crc == 16'h0 && header == 32'h0, "R6 value", header, 32'h0);
            return;
        end
        chk(!done && crc == 16'h0 && in_ready, "R1 cleared", {done, in_ready, crc}, 32'h1_0000);
        for (int i = 0; i < n; i++) begin
            logic [31:0] d;
            int gaps = $urandom_range(0, gap_max);
            in_valid = 1'b0;
            repeat (gaps) begin
                chk(in_ready && crc == m, "R2 waiting", {in_ready, crc}, {1'b1, m});
                @(negedge clk);
            end
            d = $urandom;
            in_data = d;
            in_valid = 1'b1;
            @(negedge clk);
            m = model_quad(m, d);
            for (int j = 1; j <= 7; j++) begin
                chk(!in_ready, "R5 busy", 32'(in_ready), 32'd0);
                in_valid = 1'($urandom_range(0, 1));
                in_data = $urandom;
                @(negedge clk);
            end
            in_valid = 1'b0;
            if (i < n - 1)
                chk(in_ready && !done, "R5 eighth cycle ready", {done, in_ready}, 32'd1);
            else
                chk(done && !in_ready, "R10 done timing", {done, in_ready}, 32'd2);
        end
        chk(crc == m, "R3 value", 32'(crc), 32'(m));
        chk(header == {16'(n), m}, "R7 header", header, {16'(n), m});
        for (int j = 0; j < 4; j++) begin
            in_valid = 1'b1;
            in_data = $urandom;
            @(negedge clk);
            chk(done && crc == m && !in_ready, "R8 hold", {done, in_ready, crc}, {2'b10, m});
        end
        in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!done && !in_ready && crc == 0 && header == 0, "R1 reset state", header, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !in_ready && crc == 0, "R1 idle after reset", {done, in_ready, crc}, 32'h0);

        // R4 directed single-nibble vector
        do_start(1);
        in_data = 32'h0000_000F;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (7) @(negedge clk);
        chk(crc == 16'hF1EF, "R4 known vector", 32'(crc), 32'hF1EF);
        chk(header == 32'h0001_F1EF, "R7 known header", header, 32'h0001_F1EF);

        // R6 zero length, directly after a completed block
        feed_block(0, 0);

        // R9 abort in the middle of a quadlet
        do_start(3);
        in_data = $urandom;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        do_start(2);
        chk(crc == 16'h0 && in_ready && !done, "R9 restart", {done, in_ready, crc}, 32'h1_0000);
        feed_block(2, 2);

        for (int b = 0; b < 25; b++)
            feed_block($urandom_range(1, 12), 3);

        feed_block(1, 0);
        feed_block(0, 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule